// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block runs the handoff of a clock generator's dual-purpose pads from configuration inputs to clock outputs. Once the supply-good input rises, it counts a fixed startup window in reference-clock cycles. For the whole window every shared pad stays in high impedance, so the external strapping resistors set the pad levels.

When the window ends, the block samples all five pad levels in a single clock edge. Four of them become frequency-select bits and one becomes a mode bit. The captured set then stays fixed until the supply drops. In the next cycle the block enables the pad output drivers and raises a done flag.

The mode bit decides the role of a separate auxiliary pin. That pin can be a reference clock output, which is then driven, or a stop-control input, which is never driven. The highest frequency-select pad has a weak pull-down, so it reads as 0 when nothing drives it. Taking supply-good low clears everything asynchronously.

Top module: `strap_seq_top`

## Requirements
- R1: While the startup window runs, all shared-pad output enables, the auxiliary enable, the stop-select output and `done` are 0.
- R2: At the clock edge that ends a window of `WINDOW_CYCLES` edges after supply-good rises, the block captures the pad levels. Pads 0..3 go to `fs_cfg[0..3]` and pad 4 goes to `mode_cfg`. Before that edge, `fs_cfg` and `mode_cfg` read 0.
- R3: Pad output enables and `done` rise together at the edge one cycle after capture and no earlier. At that edge every bit of `pad_oe` becomes 1.
- R4: After capture, changes on the pad levels have no effect on `fs_cfg`, `mode_cfg`, `pad_oe` or `done`. These outputs hold until supply-good falls.
- R5: If `pad_float[3]` is 1 at the capture edge, `fs_cfg[3]` is 0 whatever `pad_lvl[3]` shows. On every other pad, the float flag is ignored and the raw level is captured.
- R6: With mode captured as 1, `aux_oe` rises with `done` and `stop_sel` stays 0. With mode captured as 0, `stop_sel` rises with `done` and `aux_oe` stays 0.
- R7: Supply-good going low clears the configuration, enables, `stop_sel` and `done` at once, without waiting for a clock edge.
- R8: When supply-good rises again, a complete new window runs and the pads are sampled afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| supply_ok | input | 1 | Supply-good indication; low acts as asynchronous clear |
| pad_lvl | input | 5 | Sampled levels of the shared pads (0..3 select, 4 mode) |
| pad_float | input | 5 | Per-pad flag: pad not externally driven |
| pad_oe | output | 5 | Output-driver enables of the shared pads |
| aux_oe | output | 1 | Enable for the auxiliary pin as a reference output |
| stop_sel | output | 1 | Auxiliary pin acts as stop-control input |
| fs_cfg | output | 4 | Latched frequency-select bits |
| mode_cfg | output | 1 | Latched mode bit |
| done | output | 1 | Sequence complete; sticky until power loss |

## Verification
A counter that ends early or late moves the capture edge and the driver-enable edge. The bench counts edges from supply-good rising and checks both edges on the exact cycle. A capture register that is not held shows up as soon as the pads change after capture, so the bench toggles every pad then and checks that the configuration keeps its value. A wrong pull-down rule or a swapped role of the mode bit changes the configuration or the auxiliary outputs in the cycle that `done` rises. A clear that waits for a clock is caught by sampling the outputs before the next edge after supply-good falls.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_BITS      = 4;
  localparam int PAD_COUNT    = FS_BITS + 1;
  localparam int PULLDOWN_PAD = FS_BITS - 1;
  localparam int MODE_PAD     = FS_BITS;

  typedef struct packed {
    logic               mode;
    logic [FS_BITS-1:0] fs;
  } strap_cfg_t;
endpackage

// File: rtl/window_timer.sv
module window_timer #(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_o,
  output logic running_o
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (cnt == LAST) expired <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end

  assign sample_o  = !expired && (cnt == LAST);
  assign running_o = !expired;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R2
  expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired && $stable(cnt));
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic [PAD_COUNT-1:0] pad_lvl_i,
  input  logic [PAD_COUNT-1:0] pad_float_i,
  output strap_cfg_t           cfg_o,
  output logic                 latched_o
);
  logic [PAD_COUNT-1:0] resolved;
  logic [PAD_COUNT-1:0] held;

  for (genvar i = 0; i < PAD_COUNT; i++) begin : g_pad
    if (i == PULLDOWN_PAD) begin : g_pd
      assign resolved[i] = pad_lvl_i[i] & ~pad_float_i[i];
    end else begin : g_raw
      assign resolved[i] = pad_lvl_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     held[i] <= 1'b0;
      else if (sample_i && !latched_o) held[i] <= resolved[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latched_o <= 1'b0;
    else if (sample_i) latched_o <= 1'b1;
  end

  assign cfg_o.fs   = held[FS_BITS-1:0];
  assign cfg_o.mode = held[MODE_PAD];

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o |=> $stable(held) && latched_o);
  // R2
  pre_latch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latched_o |-> held == '0);
endmodule

// File: rtl/drive_enable.sv
module drive_enable
  import strap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 latched_i,
  input  logic                 mode_i,
  output logic [PAD_COUNT-1:0] pad_oe_o,
  output logic                 aux_oe_o,
  output logic                 stop_sel_o,
  output logic                 done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_oe_o   <= '0;
      aux_oe_o   <= 1'b0;
      stop_sel_o <= 1'b0;
      done_o     <= 1'b0;
    end else if (latched_i && !done_o) begin
      pad_oe_o   <= '1;
      aux_oe_o   <= mode_i;
      stop_sel_o <= !mode_i;
      done_o     <= 1'b1;
    end
  end

  // R3
  oe_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(latched_i));
  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && $stable(pad_oe_o));
  // R6
  aux_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(aux_oe_o && stop_sel_o));
  // R1
  no_drive_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latched_i |-> pad_oe_o == '0 && !done_o);
endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
  import strap_pkg::*;
#(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic                 clk,
  input  logic                 supply_ok,
  input  logic [PAD_COUNT-1:0] pad_lvl,
  input  logic [PAD_COUNT-1:0] pad_float,
  output logic [PAD_COUNT-1:0] pad_oe,
  output logic                 aux_oe,
  output logic                 stop_sel,
  output logic [FS_BITS-1:0]   fs_cfg,
  output logic                 mode_cfg,
  output logic                 done
);
  logic       sample;
  logic       running;
  logic       latched;
  strap_cfg_t cfg;

  window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (supply_ok),
    .sample_o  (sample),
    .running_o (running)
  );

  strap_capture u_cap (
    .clk         (clk),
    .rst_n       (supply_ok),
    .sample_i    (sample),
    .pad_lvl_i   (pad_lvl),
    .pad_float_i (pad_float),
    .cfg_o       (cfg),
    .latched_o   (latched)
  );

  drive_enable u_drv (
    .clk        (clk),
    .rst_n      (supply_ok),
    .latched_i  (latched),
    .mode_i     (cfg.mode),
    .pad_oe_o   (pad_oe),
    .aux_oe_o   (aux_oe),
    .stop_sel_o (stop_sel),
    .done_o     (done)
  );

  assign fs_cfg   = cfg.fs;
  assign mode_cfg = cfg.mode;

  // R1
  window_quiet_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    running |-> !done && pad_oe == '0);
endmodule

// File: tb/strap_seq_top_tb.sv
module strap_seq_top_tb;
  localparam int W = 20;

  logic       clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic [4:0] pad_lvl = '0;
  logic [4:0] pad_float = '0;
  logic [4:0] pad_oe;
  logic       aux_oe, stop_sel, mode_cfg, done;
  logic [3:0] fs_cfg;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  strap_seq_top #(.WINDOW_CYCLES(W)) u_dut (
    .clk(clk), .supply_ok(supply_ok), .pad_lvl(pad_lvl), .pad_float(pad_float),
    .pad_oe(pad_oe), .aux_oe(aux_oe), .stop_sel(stop_sel),
    .fs_cfg(fs_cfg), .mode_cfg(mode_cfg), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int outs();
    return {pad_oe, aux_oe, stop_sel, fs_cfg, mode_cfg, done};
  endfunction

  // Raise supply, check window quiet, capture edge and enable edge.
  task automatic run_seq(input logic [4:0] lvl, input logic [4:0] flt, input string tag);
    logic [3:0] exp_fs;
    bit early_bad = 0;
    pad_lvl = lvl; pad_float = flt;
    @(negedge clk) supply_ok = 1'b1;
    for (int k = 0; k < W - 1; k++) begin
      @(negedge clk);
      if (outs() != 0) early_bad = 1;
    end
    check(!early_bad, {tag, " R1 window quiet / R2 cfg zero before capture"}, outs(), 0);
    @(negedge clk);
    exp_fs = lvl[3:0];
    if (flt[3]) exp_fs[3] = 1'b0;
    check(fs_cfg == exp_fs && mode_cfg == lvl[4], {tag, " R2 R5 capture"},
          {fs_cfg, mode_cfg}, {exp_fs, lvl[4]});
    check(pad_oe == 0 && !done, {tag, " R3 no enable at capture edge"}, {pad_oe, done}, 0);
    @(negedge clk);
    check(pad_oe == 5'h1f && done, {tag, " R3 enable next cycle"}, {pad_oe, done}, 6'h3f);
    check(aux_oe == lvl[4] && stop_sel == !lvl[4], {tag, " R6 aux role"},
          {aux_oe, stop_sel}, {lvl[4], !lvl[4]});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(outs() == 0, "R7 reset state", outs(), 0);
  endtask

  task automatic t_ignore();
    int snap;
    snap = outs();
    pad_lvl = ~pad_lvl; pad_float = ~pad_float;
    repeat (5) @(negedge clk);
    check(outs() == snap, "R4 pads ignored after capture", outs(), snap);
  endtask

  task automatic t_async();
    #3 supply_ok = 1'b0;
    #2;
    check(outs() == 0, "R7 async clear", outs(), 0);
  endtask

  task automatic t_abort_midwindow();
    @(negedge clk) supply_ok = 1'b1;
    repeat (W / 2) @(negedge clk);
    supply_ok = 1'b0;
    #1;
    check(outs() == 0, "R7 clear mid-window", outs(), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_seq(5'b1_0110, 5'b00000, "mode1");
        t_ignore();
        t_async();
        run_seq(5'b0_1001, 5'b00000, "R8 mode0");
        t_async();
        run_seq(5'b1_1111, 5'b01000, "R5 pulldown");
        t_async();
        run_seq(5'b0_0101, 5'b10111, "R5 others raw");
        t_ignore();
        t_async();
        t_abort_midwindow();
        run_seq(5'b1_1010, 5'b00000, "R8 fresh window");
        t_async();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog R1 actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule